// File: doc/BRIEF.md
# Decrement-and-Skip Instruction Executor

This block carries out the two decrement-and-conditional-skip instructions of a small 8-bit processor core. It accepts a 16-bit instruction word on a valid/ready input, works out a banked 12-bit data address, reads the byte there, subtracts one (wrapping modulo 256), and sends the result either to the working register or back to the same data byte. The block then decides whether the instruction that follows, which the core has already fetched, must be thrown away and replaced by empty cycles.

One variant skips when the decremented value is zero and the other skips when it is not zero. The caller marks whether the following instruction is one word or two words long. Every instruction cycle takes four clocks, one per phase: decode, read, compute and write. A skip adds one empty instruction cycle for a one-word successor and two for a two-word successor. The byte-addressed program counter moves forward by two bytes for each instruction cycle spent. The data bytes live in an internal 4096-byte store, and a plain load port fills that store while the block is idle.

Input back-pressure is simple. `instr_ready` is high only while the block is idle. An instruction is taken on the clock edge where `instr_valid` and `instr_ready` are both high, and the caller holds the word, `next_two_word` and `bank_sel` steady until that edge. The write-back report `wb_valid` is a one-clock pulse and has no ready input, so the receiver must take it in the cycle it appears.

Top module: `dec_skip_exec`

## Requirements
- R1: Instruction bits 15:10 hold the opcode. 6'b001011 selects skip-if-zero and 6'b010011 selects skip-if-nonzero. Bit 9 is the destination select, bit 8 is the bank mode and bits 7:0 are the register offset.
- R2: The reported result `wb_data` equals the addressed byte minus one, modulo 256.
- R3: With destination select 0, the result is loaded into `w_reg` and the data byte keeps its value. With destination select 1, the result is stored into the data byte and `w_reg` keeps its value. `wb_to_mem` reports which of the two was chosen.
- R4: With bank mode 1, the data address is {bank_sel, offset}. With bank mode 0, offsets 0x00–0x7F address bank 0 and offsets 0x80–0xFF address bank 15.
- R5: Skip-if-zero skips when the result is zero. Skip-if-nonzero skips when the result is not zero.
- R6: An instruction takes 1 instruction cycle without a skip, 2 when it skips a one-word successor and 3 when it skips a two-word successor. Each instruction cycle is 4 clocks. `done` pulses in the clock after the last one, with `cycles_used` set to that count.
- R7: `pc` moves forward by 2 bytes per instruction cycle used (2, 4 or 6) at the moment `done` rises, and does not change at any other time.
- R8: `instr_ready` is low from the accepting edge until `done`, and no new instruction is taken during that span.
- R9: An opcode other than the two listed produces no write-back and changes no data byte. It takes one instruction cycle and advances `pc` by 2.
- R10: After reset, `pc` equals RESET_PC, `w_reg` is 0, `busy` is 0 and `instr_ready` is 1.
- R11: `wb_valid` is a single-clock pulse that appears in the clock after the 4th rising edge following acceptance, which is the write phase of the first instruction cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Block idle and able to take an instruction |
| instr | input | 16 | Instruction word |
| next_two_word | input | 1 | The following instruction is two words long |
| bank_sel | input | 4 | Bank select value |
| ld_en | input | 1 | Load a byte into the data store |
| ld_addr | input | 12 | Load address |
| ld_data | input | 8 | Load data |
| wb_valid | output | 1 | Write-back report pulse |
| wb_data | output | 8 | Decremented value |
| wb_to_mem | output | 1 | 1: result went to data byte, 0: to working register |
| wb_addr | output | 12 | Effective data address |
| w_reg | output | 8 | Working register |
| pc | output | PC_W | Byte-addressed program counter |
| busy | output | 1 | Instruction in progress |
| phase | output | 2 | Current phase (0 decode, 1 read, 2 compute, 3 write) |
| done | output | 1 | Instruction finished pulse |
| cycles_used | output | 2 | Instruction cycles the finished instruction took |

## Verification
The bench counts rising edges from the accepting edge. The write-back report is due just after edge 4, and `done` is due just after edge 4, 8 or 12, depending on the expected skip and successor length. Each check samples one time unit after an edge and records the edge count at which `wb_valid` and `done` first appear, so timing mistakes show up as count mismatches rather than as missed values. The two destinations are checked through a second decrement of the same byte, whose expected result depends on whether the first one wrote memory.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int BANK_W = 4;
  localparam int OFS_W  = 8;
  localparam int ADDR_W = BANK_W + OFS_W;
  localparam int DATA_W = 8;
  localparam int INSTR_W = 16;

  localparam logic [5:0] OP_DEC_SKZ  = 6'b001011;
  localparam logic [5:0] OP_DEC_SKNZ = 6'b010011;
  localparam logic [BANK_W-1:0] HI_BANK = '1;

  typedef struct packed {
    logic              legal;
    logic              skip_nz;
    logic              to_mem;
    logic [ADDR_W-1:0] addr;
  } dsk_dec_t;
endpackage

// File: rtl/dsk_decode.sv
module dsk_decode
  import dsk_pkg::*;
(
  input  logic [INSTR_W-1:0] ir,
  input  logic [BANK_W-1:0]  bank,
  output dsk_dec_t           dec
);
  logic [5:0]       opc;
  logic             bank_mode;
  logic [OFS_W-1:0] ofs;

  assign opc       = ir[15:10];
  assign bank_mode = ir[8];
  assign ofs       = ir[OFS_W-1:0];

  always_comb begin
    dec.legal   = (opc == OP_DEC_SKZ) || (opc == OP_DEC_SKNZ);
    dec.skip_nz = (opc == OP_DEC_SKNZ);
    dec.to_mem  = ir[9];
    if (bank_mode)
      dec.addr = {bank, ofs};
    else if (ofs[OFS_W-1])
      dec.addr = {HI_BANK, ofs};
    else
      dec.addr = {{BANK_W{1'b0}}, ofs};
  end
endmodule

// File: rtl/dsk_datamem.sv
module dsk_datamem
  import dsk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      store[waddr] <= wdata;
    else if (ld_en)
      store[ld_addr] <= ld_data;
    if (re)
      rdata <= store[raddr];
  end
endmodule

// File: rtl/dsk_seq.sv
module dsk_seq
  import dsk_pkg::*;
#(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic               two_word,
  input  logic [BANK_W-1:0]  bank_in,
  output logic [INSTR_W-1:0] ir,
  output logic [BANK_W-1:0]  bank_q,
  input  dsk_dec_t           dec_in,
  output logic               mem_re,
  output logic [ADDR_W-1:0]  mem_raddr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_waddr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               wb_valid,
  output logic [DATA_W-1:0]  wb_data,
  output logic               wb_to_mem,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [DATA_W-1:0]  w_reg,
  output logic [PC_W-1:0]    pc,
  output logic               busy,
  output logic [1:0]         phase,
  output logic               done,
  output logic [1:0]         cycles_used
);
  localparam logic [1:0] PH_DEC = 2'd0;
  localparam logic [1:0] PH_RD  = 2'd1;
  localparam logic [1:0] PH_EX  = 2'd2;
  localparam logic [1:0] PH_WR  = 2'd3;

  dsk_dec_t          dec_q;
  logic              tw_q;
  logic [1:0]        cyc;
  logic [1:0]        need_q;
  logic [1:0]        need_c;
  logic [1:0]        need_now;
  logic [DATA_W-1:0] result;
  logic              first_cyc;
  logic              skip_c;

  assign first_cyc = (cyc == 2'd0);
  assign skip_c    = dec_q.skip_nz ? (result != '0) : (result == '0);
  assign need_c    = !dec_q.legal ? 2'd1 : (skip_c ? (tw_q ? 2'd3 : 2'd2) : 2'd1);
  assign need_now  = first_cyc ? need_c : need_q;

  assign mem_re    = busy && phase == PH_RD && first_cyc && dec_q.legal;
  assign mem_raddr = dec_q.addr;
  assign mem_we    = busy && phase == PH_WR && first_cyc && dec_q.legal && dec_q.to_mem;
  assign mem_waddr = dec_q.addr;
  assign mem_wdata = result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      phase       <= PH_DEC;
      cyc         <= 2'd0;
      need_q      <= 2'd1;
      done        <= 1'b0;
      wb_valid    <= 1'b0;
      wb_data     <= '0;
      wb_to_mem   <= 1'b0;
      wb_addr     <= '0;
      w_reg       <= '0;
      pc          <= RESET_PC;
      cycles_used <= 2'd0;
      ir          <= '0;
      bank_q      <= '0;
      tw_q        <= 1'b0;
      dec_q       <= '0;
      result      <= '0;
    end else begin
      done     <= 1'b0;
      wb_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          phase  <= PH_DEC;
          cyc    <= 2'd0;
          ir     <= instr;
          tw_q   <= two_word;
          bank_q <= bank_in;
        end
      end else begin
        phase <= phase + 2'd1;
        if (first_cyc) begin
          case (phase)
            PH_DEC: dec_q  <= dec_in;
            PH_EX:  result <= mem_rdata - 8'd1;
            PH_WR: begin
              need_q <= need_c;
              if (dec_q.legal) begin
                wb_valid  <= 1'b1;
                wb_data   <= result;
                wb_to_mem <= dec_q.to_mem;
                wb_addr   <= dec_q.addr;
                if (!dec_q.to_mem) w_reg <= result;
              end
            end
            default: ;
          endcase
        end
        if (phase == PH_WR) begin
          if (cyc + 2'd1 == need_now) begin
            busy        <= 1'b0;
            done        <= 1'b1;
            cycles_used <= need_now;
            pc          <= pc + PC_W'({need_now, 1'b0});
          end else begin
            cyc <= cyc + 2'd1;
          end
        end
      end
    end
  end

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_wb_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc));
  assert_cycles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles_used != 2'd0 && !busy));
  assert_w_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_to_mem) |-> $stable(w_reg));
endmodule

// File: rtl/dec_skip_exec.sv
module dec_skip_exec
  import dsk_pkg::*;
#(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr,
  input  logic               next_two_word,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               ld_en,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [DATA_W-1:0]  ld_data,
  output logic               wb_valid,
  output logic [DATA_W-1:0]  wb_data,
  output logic               wb_to_mem,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [DATA_W-1:0]  w_reg,
  output logic [PC_W-1:0]    pc,
  output logic               busy,
  output logic [1:0]         phase,
  output logic               done,
  output logic [1:0]         cycles_used
);
  logic [INSTR_W-1:0] ir;
  logic [BANK_W-1:0]  bank_q;
  dsk_dec_t           dec_w;
  logic               mem_re, mem_we;
  logic [ADDR_W-1:0]  mem_raddr, mem_waddr;
  logic [DATA_W-1:0]  mem_rdata, mem_wdata;
  logic               start;

  assign instr_ready = !busy;
  assign start       = instr_valid && instr_ready;

  dsk_decode u_dec (
    .ir   (ir),
    .bank (bank_q),
    .dec  (dec_w)
  );

  dsk_datamem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .re      (mem_re),
    .raddr   (mem_raddr),
    .rdata   (mem_rdata)
  );

  dsk_seq #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .instr       (instr),
    .two_word    (next_two_word),
    .bank_in     (bank_sel),
    .ir          (ir),
    .bank_q      (bank_q),
    .dec_in      (dec_w),
    .mem_re      (mem_re),
    .mem_raddr   (mem_raddr),
    .mem_rdata   (mem_rdata),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .wb_valid    (wb_valid),
    .wb_data     (wb_data),
    .wb_to_mem   (wb_to_mem),
    .wb_addr     (wb_addr),
    .w_reg       (w_reg),
    .pc          (pc),
    .busy        (busy),
    .phase       (phase),
    .done        (done),
    .cycles_used (cycles_used)
  );

  assert_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_addr[7]) |-> (wb_addr[11:8] == 4'h0 || wb_addr[11:8] == $past(bank_q)));
  assert_write_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(phase) == 2'd3 && $past(busy)));
endmodule

// File: tb/dec_skip_exec_test.sv
module dec_skip_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr = '0;
  logic        next_two_word = 1'b0;
  logic [3:0]  bank_sel = '0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        wb_valid, wb_to_mem, busy, done;
  logic [7:0]  wb_data, w_reg;
  logic [11:0] wb_addr;
  logic [15:0] pc;
  logic [1:0]  phase, cycles_used;

  int n_chk = 0, n_bad = 0;
  int wb_at, done_at;
  logic [7:0]  cap_data;
  logic        cap_mem;
  logic [11:0] cap_addr;
  logic        saw_ready;
  logic [15:0] exp_pc = 16'd0;
  logic [7:0]  exp_w = 8'd0;

  always #2.5 clk = ~clk;

  dec_skip_exec uut (.*);

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic issue(input logic [15:0] w, input logic tw, input logic [3:0] b);
    int n;
    @(negedge clk);
    instr = w; next_two_word = tw; bank_sel = b; instr_valid = 1'b1;
    @(posedge clk);
    #1 instr_valid = 1'b0;
    n = 0; wb_at = -1; done_at = -1; saw_ready = 1'b0;
    while (done_at < 0 && n < 40) begin
      @(posedge clk);
      n++;
      #1;
      if (wb_valid && wb_at < 0) begin
        wb_at = n; cap_data = wb_data; cap_mem = wb_to_mem; cap_addr = wb_addr;
      end
      if (!done && instr_ready) saw_ready = 1'b1;
      if (done) done_at = n;
    end
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R10 pc", pc == 16'd0, pc, 0);
    chk("R10 w_reg", w_reg == 8'd0, w_reg, 0);
    chk("R10 busy", busy == 1'b0, busy, 0);
    chk("R10 ready", instr_ready == 1'b1, instr_ready, 1);

    for (int v = 0; v < 256; v++) begin
      for (int o = 0; o < 2; o++) begin
        logic [7:0] val, f, res, res2;
        logic d, a, tw, skip, skip2;
        logic [3:0] b;
        logic [11:0] eff;
        logic [5:0] opc;
        int cyc, cyc2;
        val = 8'(v); d = val[1]; a = val[2]; tw = val[0] ^ 1'(o); b = val[6:3] ^ 4'(o * 5);
        f = 8'(v * 37 + o * 11);
        opc = o ? 6'b010011 : 6'b001011;
        eff = a ? {b, f} : (f[7] ? {4'hF, f} : {4'h0, f});
        res = val - 8'd1;
        skip = o ? (res != 0) : (res == 0);
        cyc = skip ? (tw ? 3 : 2) : 1;
        load(eff, val);
        issue({opc, d, a, f}, tw, b);
        exp_pc = exp_pc + 16'(2 * cyc);
        if (!d) exp_w = res;
        chk("R11 wb timing", wb_at == 4, wb_at, 4);
        chk("R2 result", cap_data == res, cap_data, res);
        chk("R1 R3 dest", cap_mem == d, cap_mem, d);
        chk("R4 address", cap_addr == eff, cap_addr, eff);
        chk("R5 R6 done time", done_at == 4 * cyc, done_at, 4 * cyc);
        chk("R6 cycles_used", cycles_used == 2'(cyc), cycles_used, cyc);
        chk("R7 pc", pc == exp_pc, pc, exp_pc);
        chk("R3 w_reg", w_reg == exp_w, w_reg, exp_w);
        chk("R8 ready low", !saw_ready, saw_ready, 0);
        // second decrement of the same byte, writing back: reveals whether the first stored
        res2 = d ? val - 8'd2 : val - 8'd1;
        skip2 = (res2 == 0);
        cyc2 = skip2 ? 2 : 1;
        issue({6'b001011, 1'b1, 1'b1, eff[7:0]}, 1'b0, eff[11:8]);
        exp_pc = exp_pc + 16'(2 * cyc2);
        chk("R3 memory state", cap_data == res2, cap_data, res2);
        chk("R5 R6 second done", done_at == 4 * cyc2, done_at, 4 * cyc2);
        chk("R7 second pc", pc == exp_pc, pc, exp_pc);
      end
    end

    // R9: unknown opcode does nothing but spend one cycle
    for (int k = 0; k < 4; k++) begin
      logic [5:0] bad_op;
      logic [7:0] seed;
      bad_op = (k == 0) ? 6'b000000 : (k == 1) ? 6'b001010 : (k == 2) ? 6'b010010 : 6'b111111;
      seed = 8'(40 + k);
      load({4'h3, 8'(k)}, seed);
      issue({bad_op, 1'b1, 1'b1, 8'(k)}, 1'b1, 4'h3);
      exp_pc = exp_pc + 16'd2;
      chk("R9 no writeback", wb_at < 0, wb_at, -1);
      chk("R9 one cycle", done_at == 4, done_at, 4);
      chk("R9 pc", pc == exp_pc, pc, exp_pc);
      chk("R9 w_reg", w_reg == exp_w, w_reg, exp_w);
      issue({6'b001011, 1'b1, 1'b1, 8'(k)}, 1'b0, 4'h3);
      exp_pc = exp_pc + 16'd2;
      chk("R9 memory untouched", cap_data == seed - 8'd1, cap_data, seed - 8'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule